// File: doc/BRIEF.md
# I2C Register Target with Program Memory Loader

This block is an I2C target that a host controller uses to reach a small file of 12-bit control registers addressed by 16-bit address words. It also fronts a program memory of 16-bit words. The host fills that memory through an auto-incrementing data port, either one word per transaction or in streamed bursts. SCL and SDA are sampled in the system clock domain. The target pulls SDA low through an open-drain enable.

A write frame carries the device address, two address bytes and two data bytes, most significant byte first. A read frame writes the two address bytes, issues a repeated START, and then reads two bytes.

The two top bits of the address word select the pointer width and the burst mode. Bit 15 makes the memory pointer 13 bits wide, and bit 14 turns on multibyte streaming into the data port. Loading the pointer with all ones and making one dummy write wraps it to word 0, ready for an upload.

A run/stop register drives the embedded controller's run input. A soft-reset register clears the control state. The controller reads program words through a separate asynchronous read port.

Top module: `prog_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit device address 0x70 (first byte 0xE0 for a write, 0xE1 for a read). It NACKs any other address and ignores the rest of that frame.
- R2: A write frame holds address high, address low, data high and data low. The register is selected by address bits 11:0 with bits 13:12 equal to zero. Data bytes after the fourth are acknowledged and ignored (except on the streaming port).
- R3: A read frame returns the selected register as {4'h0, value[11:0]}, high byte first.
- R4: Unmapped addresses read as 0. Writes to them are acknowledged and change nothing.
- R5: Bit 0 of the word written to register 0xF00 sets run_o (1 = run, 0 = stop), and the register reads back that bit. It is 0 after reset.
- R6: Writing register 0xF08 loads the pointer with data bits 12:0 when address bit 15 is set, and with bits 11:0 (bit 12 cleared) otherwise. Reads return pointer bits 11:0.
- R7: A four-byte write to the data port 0xF0A stores the 16-bit word at the pointer and then increments the pointer, modulo 2^13 when address bit 15 is set and modulo 2^12 otherwise. Memory words are indexed by the pointer's low log2(MEM_DEPTH) bits.
- R8: With address bit 14 set on register 0xF0A, every data byte is accepted. The bytes pair into words, high byte first, and each completed word is stored at the pointer before the pointer advances by one.
- R9: A STOP or a repeated START ends streaming, and a byte left without its partner is discarded.
- R10: Writing 0 to register 0xF1A clears run_o, the pointer and the scratch register 0xF09. The memory contents are kept. A nonzero write to 0xF1A has no effect.
- R11: Reading register 0xF0A returns the low 12 bits of the memory word at the pointer and leaves the pointer unchanged.
- R12: prog_data_o shows the memory word at prog_addr_i with no clock delay.
- R13: The target changes its SDA drive only while SCL is low. It drives the acknowledge bit and the read data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| run_o | output | 1 | Embedded controller run enable |
| prog_addr_i | input | AW | Program memory read address, AW = log2(MEM_DEPTH) |
| prog_data_o | output | 16 | Program memory read data |

## Verification
The bench builds the target with MEM_DEPTH set to 64 and the default device address 0x70. At that depth the all-ones pointer 0x1FFF lands on word 63, so the dummy-write wrap is visible on the program read port. The 12-bit and 13-bit pointer carries also alias onto small indices, so both modes can be told apart with a short memory. Random bursts start at random pointers and stay inside the 64 words, so every stored word can be read back and compared.

// File: rtl/prog_slave_pkg.sv
package prog_slave_pkg;
  localparam int PTR_W = 13;

  localparam logic [11:0] REG_RUN  = 12'hF00;
  localparam logic [11:0] REG_PTR  = 12'hF08;
  localparam logic [11:0] REG_AUX  = 12'hF09;
  localparam logic [11:0] REG_PORT = 12'hF0A;
  localparam logic [11:0] REG_SRST = 12'hF1A;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_MACK, BUS_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_byte_if.sv
module i2c_byte_if
  import prog_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  input  logic [7:0] tx_byte_i,
  output logic       tx_adv_o
);
  logic [2:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;
  logic rise, fall, start_c, stop_c;

  bus_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic       first_q, rd_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_s   = scl_sh[1];
  assign scl_p   = scl_sh[2];
  assign sda_s   = sda_sh[1];
  assign sda_p   = sda_sh[2];
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rx_byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= BUS_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      first_q    <= 1'b0;
      rd_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_adv_o   <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_adv_o   <= 1'b0;
      if (start_c) begin
        st_q     <= BUS_RX;
        cnt_q    <= '0;
        first_q  <= 1'b1;
        sda_oe_o <= 1'b0;
        start_o  <= 1'b1;
      end else if (stop_c) begin
        st_q     <= BUS_IDLE;
        sda_oe_o <= 1'b0;
        stop_o   <= 1'b1;
      end else begin
        unique case (st_q)
          BUS_RX: begin
            if (rise && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (fall && cnt_q == 4'd8) begin
              if (first_q) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  sda_oe_o <= 1'b1;
                  rd_q     <= sh_q[0];
                  first_q  <= 1'b0;
                  st_q     <= BUS_ACK;
                end else begin
                  st_q <= BUS_SKIP;
                end
              end else begin
                rx_valid_o <= 1'b1;
                sda_oe_o   <= 1'b1;
                st_q       <= BUS_ACK;
              end
            end
          end
          BUS_ACK: begin
            if (fall) begin
              if (rd_q) begin
                sh_q     <= tx_byte_i;
                sda_oe_o <= ~tx_byte_i[7];
                cnt_q    <= 4'd1;
                tx_adv_o <= 1'b1;
                st_q     <= BUS_TX;
              end else begin
                sda_oe_o <= 1'b0;
                cnt_q    <= '0;
                st_q     <= BUS_RX;
              end
            end
          end
          BUS_TX: begin
            if (fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= BUS_MACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
                cnt_q    <= cnt_q + 4'd1;
              end
            end
          end
          BUS_MACK: begin
            if (rise) mack_q <= ~sda_s;
            if (fall) begin
              if (mack_q) begin
                sh_q     <= tx_byte_i;
                sda_oe_o <= ~tx_byte_i[7];
                cnt_q    <= 4'd1;
                tx_adv_o <= 1'b1;
                st_q     <= BUS_TX;
              end else begin
                st_q <= BUS_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13: drive toward low only starts while SCL is low
  assert_sda_drive_scl_low_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  // R2: each received data byte is handed over exactly once
  assert_rx_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/prog_mem.sv
module prog_mem #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [15:0]   rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [15:0]   rdata_b_o
);
  logic [15:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/prog_slave_regs.sv
module prog_slave_regs
  import prog_slave_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          tx_adv_i,
  output logic [7:0]    tx_byte_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [15:0]   mem_wdata_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          run_o
);
  logic [15:0]      addr_q;
  logic [2:0]       wcnt_q;
  logic [7:0]       dhi_q;
  logic             half_q;
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             run_q;
  logic [11:0]      aux_q, rd_val;
  logic [1:0]       rd_idx_q;
  logic             in_data, streaming, commit, stream_word, soft_hit, w13;
  logic             hit_run, hit_ptr, hit_aux, hit_port, hit_srst;
  logic [15:0]      wr_word;

  assign hit_run  = addr_q[13:12] == 2'b00 && addr_q[11:0] == REG_RUN;
  assign hit_ptr  = addr_q[13:12] == 2'b00 && addr_q[11:0] == REG_PTR;
  assign hit_aux  = addr_q[13:12] == 2'b00 && addr_q[11:0] == REG_AUX;
  assign hit_port = addr_q[13:12] == 2'b00 && addr_q[11:0] == REG_PORT;
  assign hit_srst = addr_q[13:12] == 2'b00 && addr_q[11:0] == REG_SRST;

  assign w13         = addr_q[15];
  assign in_data     = wcnt_q >= 3'd2;
  assign streaming   = addr_q[14] && hit_port;
  assign wr_word     = {dhi_q, rx_byte_i};
  assign commit      = rx_valid_i && wcnt_q == 3'd3 && !streaming;
  assign stream_word = rx_valid_i && in_data && streaming && half_q;
  assign soft_hit    = commit && hit_srst && wr_word == 16'h0000;

  always_comb begin
    ptr_inc = ptr_q + 1'b1;
    if (!w13) ptr_inc[PTR_W-1] = 1'b0;
  end

  assign mem_we_o    = (commit && hit_port) || stream_word;
  assign mem_waddr_o = ptr_q[AW-1:0];
  assign mem_wdata_o = wr_word;
  assign mem_raddr_o = ptr_q[AW-1:0];
  assign run_o       = run_q;

  always_comb begin
    rd_val = 12'h000;
    if (hit_run)  rd_val = {11'h000, run_q};
    if (hit_ptr)  rd_val = ptr_q[11:0];
    if (hit_aux)  rd_val = aux_q;
    if (hit_port) rd_val = mem_rdata_i[11:0];
  end

  always_comb begin
    unique case (rd_idx_q)
      2'd0:    tx_byte_o = {4'h0, rd_val[11:8]};
      2'd1:    tx_byte_o = rd_val[7:0];
      default: tx_byte_o = 8'h00;
    endcase
  end

  // frame sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wcnt_q   <= '0;
      dhi_q    <= '0;
      half_q   <= 1'b0;
      rd_idx_q <= '0;
    end else if (start_i || stop_i) begin
      wcnt_q   <= '0;
      half_q   <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      if (rx_valid_i) begin
        unique case (wcnt_q)
          3'd0: addr_q[15:8] <= rx_byte_i;
          3'd1: addr_q[7:0]  <= rx_byte_i;
          default: begin
            if (streaming) begin
              if (!half_q) dhi_q <= rx_byte_i;
              half_q <= ~half_q;
            end else if (wcnt_q == 3'd2) begin
              dhi_q <= rx_byte_i;
            end
          end
        endcase
        if (wcnt_q < 3'd4) wcnt_q <= wcnt_q + 3'd1;
      end
      if (tx_adv_i && rd_idx_q != 2'd3) rd_idx_q <= rd_idx_q + 2'd1;
    end
  end

  // control state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ptr_q <= '0;
      aux_q <= '0;
    end else if (soft_hit) begin
      run_q <= 1'b0;
      ptr_q <= '0;
      aux_q <= '0;
    end else if (commit) begin
      if (hit_run)  run_q <= wr_word[0];
      if (hit_ptr)  ptr_q <= w13 ? wr_word[12:0] : {1'b0, wr_word[11:0]};
      if (hit_aux)  aux_q <= wr_word[11:0];
      if (hit_port) ptr_q <= ptr_inc;
    end else if (stream_word) begin
      ptr_q <= ptr_inc;
    end
  end

  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> ptr_q[11:0] == $past(ptr_q[11:0]) + 12'd1);

  assert_soft_reset_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_hit |=> (ptr_q == '0 && !run_q && aux_q == '0));

  assert_run_changes_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(run_q) |-> $past(commit));

  assert_no_stream_before_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wcnt_q >= 3'd2);
endmodule

// File: rtl/prog_i2c_target.sv
module prog_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h70,
  parameter int MEM_DEPTH = 1024,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          run_o,
  input  logic [AW-1:0] prog_addr_i,
  output logic [15:0]   prog_data_o
);
  logic          start_w, stop_w, rx_valid_w, tx_adv_w, mem_we_w;
  logic [7:0]    rx_byte_w, tx_byte_w;
  logic [AW-1:0] mem_waddr_w, mem_raddr_w;
  logic [15:0]   mem_wdata_w, mem_rdata_w;

  i2c_byte_if #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .start_o(start_w), .stop_o(stop_w),
    .rx_valid_o(rx_valid_w), .rx_byte_o(rx_byte_w),
    .tx_byte_i(tx_byte_w), .tx_adv_o(tx_adv_w)
  );

  prog_slave_regs #(.AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_w), .stop_i(stop_w),
    .rx_valid_i(rx_valid_w), .rx_byte_i(rx_byte_w), .tx_adv_i(tx_adv_w),
    .tx_byte_o(tx_byte_w), .mem_we_o(mem_we_w), .mem_waddr_o(mem_waddr_w),
    .mem_wdata_o(mem_wdata_w), .mem_raddr_o(mem_raddr_w),
    .mem_rdata_i(mem_rdata_w), .run_o(run_o)
  );

  prog_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i(clk_i), .we_i(mem_we_w), .waddr_i(mem_waddr_w), .wdata_i(mem_wdata_w),
    .raddr_a_i(mem_raddr_w), .rdata_a_o(mem_rdata_w),
    .raddr_b_i(prog_addr_i), .rdata_b_o(prog_data_o)
  );
endmodule

// File: tb/sim_prog_i2c_target.sv
module sim_prog_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, run, sda_line;
  logic [AW-1:0] paddr = '0;
  logic [15:0] pdata;

  int total = 0;
  int bad = 0;

  logic [15:0] exp_mem [DEPTH];
  logic        exp_valid [DEPTH];
  int          exp_ptr;

  assign sda_line = sda_m & ~sda_oe;

  prog_i2c_target #(.DEV_ADDR(7'h70), .MEM_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .run_o(run), .prog_addr_i(paddr), .prog_data_o(pdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0;
    end
    sda_m = 1'b1; qw; scl_m = 1'b1; qw; ack = ~sda_line; qw; scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw; scl_m = 1'b1; qw; b[i] = sda_line; qw; scl_m = 1'b0;
    end
    sda_m = ~give_ack; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [15:0] d, output logic ok);
    logic k0, k1, k2, k3, k4;
    i2c_start;
    send_byte(8'hE0, k0); send_byte(a[15:8], k1); send_byte(a[7:0], k2);
    send_byte(d[15:8], k3); send_byte(d[7:0], k4);
    i2c_stop;
    ok = k0 & k1 & k2 & k3 & k4;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [15:0] d);
    logic k;
    logic [7:0] hi, lo;
    i2c_start;
    send_byte(8'hE0, k); send_byte(a[15:8], k); send_byte(a[7:0], k);
    i2c_start;
    send_byte(8'hE1, k);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    i2c_stop;
    d = {hi, lo};
  endtask

  // streamed upload of n random bytes to the data port, model updated
  task automatic burst(input int n, input string req);
    logic k;
    logic [7:0] b, hold;
    i2c_start;
    send_byte(8'hE0, k); send_byte(8'hCF, k); send_byte(8'h0A, k);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      send_byte(b, k);
      chk({req, " data byte ack"}, 32'(k), 32'd1);
      if (i % 2 == 0) hold = b;
      else begin
        exp_mem[exp_ptr % DEPTH] = {hold, b};
        exp_valid[exp_ptr % DEPTH] = 1'b1;
        exp_ptr = (exp_ptr + 1) & 32'h1FFF;
      end
    end
    i2c_stop;
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      if (exp_valid[i]) begin
        paddr = AW'(i);
        #1;
        chk(req, 32'(pdata), 32'(exp_mem[i]));
      end
    end
  endtask

  task automatic check_ptr(input string req);
    logic [15:0] d;
    reg_read(16'h0F08, d);
    chk(req, 32'(d), 32'(exp_ptr & 12'hFFF));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [15:0] d, v;
    logic [7:0] b0, b1, b2, hi, lo;
    int unsigned seed;
    seed = $urandom(32'h0000C0DE);
    for (int i = 0; i < DEPTH; i++) begin exp_mem[i] = '0; exp_valid[i] = 1'b0; end
    exp_ptr = 0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R5 run after reset", 32'(run), 32'd0);
    reg_read(16'h0F00, d);
    chk("R3 read run reg after reset", 32'(d), 32'd0);

    // wrong device address
    i2c_start;
    send_byte(8'hE2, k);
    chk("R1 nack foreign address", 32'(k), 32'd0);
    send_byte(8'h0F, k); send_byte(8'h09, k); send_byte(8'h05, k); send_byte(8'h55, k);
    i2c_stop;
    reg_read(16'h0F09, d);
    chk("R1 foreign frame ignored", 32'(d), 32'd0);

    // scratch register with random data
    for (int i = 0; i < 4; i++) begin
      v = 16'($urandom);
      reg_write({4'b0000, 12'hF09} | {1'b0, 1'($urandom), 14'h0}, v, ok);
      chk("R1 write acked", 32'(ok), 32'd1);
      reg_read(16'h0F09, d);
      chk("R3 scratch readback", 32'(d), 32'(v & 16'h0FFF));
    end

    // unmapped
    reg_write(16'h0123, 16'hABCD, ok);
    chk("R4 unmapped write acked", 32'(ok), 32'd1);
    reg_read(16'h0123, d);
    chk("R4 unmapped reads 0", 32'(d), 32'd0);
    reg_write(16'h1F09, 16'h0777, ok);
    reg_read(16'h0F09, d);
    chk("R4 address bit12 makes unmapped", 32'(d), 32'(v & 16'h0FFF));

    // run register
    reg_write(16'h0F00, 16'h0001, ok);
    @(negedge clk);
    chk("R5 run set", 32'(run), 32'd1);
    reg_read(16'h0F00, d);
    chk("R5 run readback", 32'(d), 32'd1);

    // extra bytes on a register write
    i2c_start;
    send_byte(8'hE0, k); send_byte(8'h0F, k); send_byte(8'h09, k);
    send_byte(8'h0A, k); send_byte(8'hBB, k); send_byte(8'hCC, k);
    chk("R2 extra byte acked", 32'(k), 32'd1);
    send_byte(8'hDD, k);
    i2c_stop;
    reg_read(16'h0F09, d);
    chk("R2 extra bytes ignored", 32'(d), 32'h0ABB);

    // pointer all ones then dummy write wraps to 0
    reg_write(16'h8F08, 16'h1FFF, ok);
    exp_ptr = 32'h1FFF;
    check_ptr("R6 13-bit pointer load");
    reg_write(16'h8F0A, 16'h0000, ok);
    exp_mem[DEPTH-1] = 16'h0000; exp_valid[DEPTH-1] = 1'b1;
    exp_ptr = 0;
    check_ptr("R7 dummy write wraps pointer");

    // full 30-byte streaming burst
    burst(30, "R8");
    check_ptr("R8 pointer after burst");
    check_mem("R12 R8 burst contents");

    // odd byte discarded at STOP
    burst(5, "R9");
    check_ptr("R9 odd byte at stop dropped");
    check_mem("R9 contents after odd burst");

    // odd byte discarded at repeated START
    b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
    i2c_start;
    send_byte(8'hE0, k); send_byte(8'hCF, k); send_byte(8'h0A, k);
    send_byte(b0, k); send_byte(b1, k); send_byte(b2, k);
    i2c_start;
    send_byte(8'hE0, k); send_byte(8'h0F, k); send_byte(8'h08, k);
    i2c_start;
    send_byte(8'hE1, k);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    i2c_stop;
    exp_mem[exp_ptr % DEPTH] = {b0, b1}; exp_valid[exp_ptr % DEPTH] = 1'b1;
    exp_ptr = exp_ptr + 1;
    chk("R9 repeated start ends stream", 32'({hi, lo}), 32'(exp_ptr & 12'hFFF));
    burst(2, "R9");
    check_mem("R9 next word not merged with orphan");

    // 12-bit pointer mode
    reg_write(16'h0F08, 16'h1FFF, ok);
    exp_ptr = 32'h0FFF;
    check_ptr("R6 12-bit pointer load");
    reg_write(16'h0F0A, 16'hBEEF, ok);
    exp_mem[DEPTH-1] = 16'hBEEF;
    exp_ptr = 0;
    check_ptr("R7 12-bit mode wraps to 0");
    paddr = AW'(DEPTH-1); #1;
    chk("R12 R7 word stored at pointer", 32'(pdata), 32'h0000BEEF);

    // 13-bit mode carries into bit 12
    reg_write(16'h8F08, 16'h0FFF, ok);
    reg_write(16'h8F0A, 16'h1234, ok);
    reg_write(16'h8F0A, 16'h5678, ok);
    exp_mem[DEPTH-1] = 16'h1234; exp_mem[0] = 16'h5678; exp_valid[0] = 1'b1;
    exp_ptr = 32'h1001;
    check_ptr("R7 13-bit increment past 0xFFF");
    check_mem("R7 13-bit mode words");

    // random bursts
    for (int it = 0; it < 4; it++) begin
      int st, n;
      st = int'($urandom_range(0, DEPTH - 16));
      n  = int'($urandom_range(2, 24));
      reg_write(16'h8F08, 16'(st), ok);
      exp_ptr = st;
      burst(n, "R8 random");
      check_ptr("R8 R9 random burst pointer");
    end
    check_mem("R8 random burst contents");

    // data port read
    reg_write(16'h8F08, 16'h0005, ok);
    exp_ptr = 5;
    reg_read(16'h0F0A, d);
    chk("R11 port read value", 32'(d), 32'(exp_mem[5] & 16'h0FFF));
    check_ptr("R11 port read keeps pointer");

    // soft reset
    reg_write(16'h0F09, 16'h0321, ok);
    reg_write(16'h0F1A, 16'h0001, ok);
    @(negedge clk);
    chk("R10 nonzero soft reset ignored", 32'(run), 32'd1);
    reg_read(16'h0F09, d);
    chk("R10 nonzero soft reset keeps scratch", 32'(d), 32'h0321);
    reg_write(16'h0F1A, 16'h0000, ok);
    @(negedge clk);
    chk("R10 soft reset stops run", 32'(run), 32'd0);
    exp_ptr = 0;
    check_ptr("R10 soft reset clears pointer");
    reg_read(16'h0F09, d);
    chk("R10 soft reset clears scratch", 32'(d), 32'd0);
    check_mem("R10 memory kept over soft reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule